// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block arbitrates service requests for a small CPU core. It takes three kinds of request. The first is a parameterized set of peripheral request pulses, each backed by a control register that holds a request flag, an enable flag and a 4-bit priority. The second is a software trap carrying a trap number. The third is a set of hardware trap conditions. The block presents one request at a time to the CPU, together with a vector address. On acknowledge it moves the current service level to the level of the accepted service.

Only an enabled pending source whose priority is strictly above the current level is presented. Among those, the highest priority wins, and a tie goes to the lower index. Hardware traps are non-maskable and rank above everything else. The lowest-indexed pending trap is taken first, and each trap also sets a sticky bit in a trap flag register. A software trap ranks above every maskable source and leaves the level unchanged. Each acknowledge pushes the previous level onto an internal stack, and a return strobe pops it, so nested services unwind in order.

Top module: `intc_top`

## Requirements
- R1: After reset, `irq_valid` is 0, `cur_level` is 0 and `tflag_q` is all zeros.
- R2: A pulse on `src_pulse[i]` sets source i's request flag. If the source is enabled and its priority is above `cur_level`, `irq_valid` is 1 in the next cycle with `irq_vector` = N_HWT + i.
- R3: A source whose enable flag is 0, or whose priority is 0, is never presented, even while its request flag is set.
- R4: Among presentable sources the highest priority is presented. On equal priority the lowest index wins.
- R5: A maskable source is presented only if its priority is strictly greater than `cur_level`. A source at a level equal to `cur_level` waits.
- R6: When `irq_ack` is high while a maskable source is presented, that source's request flag clears and `cur_level` becomes its priority in the next cycle.
- R7: Each acknowledge pushes the old `cur_level`. `irq_ret` without acknowledge pops it back into `cur_level`, or loads 0 if the stack is empty.
- R8: A write with `cfg_we` replaces the request, enable and priority fields of source `cfg_idx`. A hardware pulse in the same cycle still sets the request.
- R9: `swt_req` pends a software trap with vector `swt_num`. It is presented above any maskable level, and its acknowledge leaves `cur_level` unchanged.
- R10: A high `hwt_cond[j]` pends hardware trap j, which is presented whatever the current level, with vector j. Lower j goes first. Its acknowledge sets `cur_level` to 16.
- R11: `hwt_cond[j]` sets `tflag_q[j]`, which stays set. A write with `tflag_we` clears each bit whose `tflag_wdata` bit is 0. A trap condition in the same cycle keeps its bit set.
- R12: All outputs are registered state. A stimulus applied at one clock edge shows at the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | N_SRC | Peripheral request pulses |
| cfg_we | input | 1 | Control register write strobe |
| cfg_idx | input | $clog2(N_SRC) | Source selected for write |
| cfg_req | input | 1 | Request flag value to write |
| cfg_en | input | 1 | Enable flag value to write |
| cfg_prio | input | 4 | Priority value to write |
| swt_req | input | 1 | Software trap strobe |
| swt_num | input | VEC_W | Software trap vector number |
| hwt_cond | input | N_HWT | Hardware trap conditions |
| tflag_we | input | 1 | Trap flag write strobe |
| tflag_wdata | input | N_HWT | Trap flag write mask (0 clears) |
| irq_ack | input | 1 | CPU accepts the presented request |
| irq_ret | input | 1 | Return from service |
| irq_valid | output | 1 | Request presented to the CPU |
| irq_vector | output | VEC_W | Vector of the presented request |
| cur_level | output | 5 | Current service level (0..16) |
| tflag_q | output | N_HWT | Trap flag register |

## Verification
Every result of this block is due one cycle after its cause. A pulse, configuration write, trap strobe, acknowledge or return applied before edge k is visible at the outputs just after edge k, because none of the outputs depend combinationally on inputs. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge from the same inputs, and the bench compares valid, vector, level and trap flags on the next falling edge, so each expectation is sampled exactly one edge after its stimulus. Scenario checks with fixed expected vectors and levels are placed at those same falling edges.

// File: rtl/intc_pkg.sv
// Shared constants for the interrupt controller.
// Assumes a 4-bit priority field and one extra level above it for hardware traps.
package intc_pkg;
    localparam int PRIO_W   = 4;
    localparam int LVL_W    = PRIO_W + 1;
    localparam int TRAP_LVL = 1 << PRIO_W;
endpackage

// File: rtl/intc_src_regs.sv
// Per-source control registers: request flag, enable flag, priority.
// Assumes at most one acknowledge clear per cycle; a pulse outranks a clear or a write.
module intc_src_regs
    import intc_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        src_pulse,
    input  logic                    cfg_we,
    input  logic [IDX_W-1:0]        cfg_idx,
    input  logic                    cfg_req,
    input  logic                    cfg_en,
    input  logic [PRIO_W-1:0]       cfg_prio,
    input  logic [N_SRC-1:0]        ack_clr,
    output logic [N_SRC-1:0]        req_q,
    output logic [N_SRC-1:0]        en_q,
    output logic [N_SRC*PRIO_W-1:0] prio_q
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // Update one source's flags from write, acknowledge and pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[i]                <= 1'b0;
                en_q[i]                 <= 1'b0;
                prio_q[i*PRIO_W+:PRIO_W] <= '0;
            end else if (cfg_we && cfg_idx == IDX_W'(i)) begin
                req_q[i]                <= cfg_req | src_pulse[i];
                en_q[i]                 <= cfg_en;
                prio_q[i*PRIO_W+:PRIO_W] <= cfg_prio;
            end else begin
                req_q[i] <= (req_q[i] & ~ack_clr[i]) | src_pulse[i];
            end
        end
    end

    // R6
    ack_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_clr) && ((ack_clr & src_pulse) == '0) && !cfg_we)
            |=> ((req_q & $past(ack_clr)) == '0));
endmodule

// File: rtl/intc_arbiter.sv
// Finds the enabled pending source of highest priority, lowest index on a tie.
// Purely combinational; the caller compares the result with the current level.
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]        req,
    input  logic [N_SRC-1:0]        en,
    input  logic [N_SRC*PRIO_W-1:0] prio,
    output logic                    any,
    output logic [IDX_W-1:0]        win_idx,
    output logic [PRIO_W-1:0]       win_prio
);
    // Scan upward; replace the winner only on strictly higher priority.
    always_comb begin
        any      = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i] && en[i] && (!any || prio[i*PRIO_W+:PRIO_W] > win_prio)) begin
                any      = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i*PRIO_W+:PRIO_W];
            end
        end
    end
endmodule

// File: rtl/intc_prio_stack.sv
// Stack of saved service levels. A push when full is dropped; a pop when empty is ignored.
// Push has precedence over pop in the same cycle.
module intc_prio_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 5,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] top,
    output logic         empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic             full;

    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
    assign top   = empty ? '0 : mem[PTR_W'(cnt - 1'b1)];

    // Move the fill count and store pushed levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push) begin
            if (!full) begin
                mem[PTR_W'(cnt)] <= push_data;
                cnt              <= cnt + 1'b1;
            end
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R7
    push_then_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (top == $past(push_data)));
endmodule

// File: rtl/intc_top.sv
// Nested vectored interrupt controller: trap latches, trap flags, level tracking
// and the choice of the presented request.
// Assumes the CPU raises irq_ack only while irq_valid is high, and does not
// nest deeper than STACK_DEPTH. Vectors: hardware trap j -> j, maskable source
// i -> N_HWT + i, software trap -> swt_num.
module intc_top
    import intc_pkg::*;
#(
    parameter int N_SRC       = 8,
    parameter int N_HWT       = 4,
    parameter int STACK_DEPTH = 8,
    parameter int VEC_W       = 8,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int HWI_W = $clog2(N_HWT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_pulse,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_req,
    input  logic              cfg_en,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              swt_req,
    input  logic [VEC_W-1:0]  swt_num,
    input  logic [N_HWT-1:0]  hwt_cond,
    input  logic              tflag_we,
    input  logic [N_HWT-1:0]  tflag_wdata,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector,
    output logic [LVL_W-1:0]  cur_level,
    output logic [N_HWT-1:0]  tflag_q
);
    logic [N_SRC-1:0]        req_q, en_q, ack_clr;
    logic [N_SRC*PRIO_W-1:0] prio_q;
    logic                    arb_any;
    logic [IDX_W-1:0]        win_idx;
    logic [PRIO_W-1:0]       win_prio;
    logic [N_HWT-1:0]        hwt_pend;
    logic                    hw_any;
    logic [HWI_W-1:0]        hw_idx;
    logic                    swt_pend;
    logic [VEC_W-1:0]        swt_vec;
    logic                    mask_take, accept, acc_hw, acc_sw, acc_mask;
    logic [LVL_W-1:0]        stk_top;
    logic                    stk_empty;

    intc_src_regs #(.N_SRC(N_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_req(cfg_req),
        .cfg_en(cfg_en), .cfg_prio(cfg_prio), .ack_clr(ack_clr),
        .req_q(req_q), .en_q(en_q), .prio_q(prio_q)
    );

    intc_arbiter #(.N_SRC(N_SRC)) u_arb (
        .req(req_q), .en(en_q), .prio(prio_q),
        .any(arb_any), .win_idx(win_idx), .win_prio(win_prio)
    );

    intc_prio_stack #(.DEPTH(STACK_DEPTH), .W(LVL_W)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(accept), .push_data(cur_level),
        .pop(irq_ret && !accept), .top(stk_top), .empty(stk_empty)
    );

    // Pick the lowest-indexed pending hardware trap.
    always_comb begin
        hw_any = 1'b0;
        hw_idx = '0;
        for (int j = N_HWT - 1; j >= 0; j--) begin
            if (hwt_pend[j]) begin
                hw_any = 1'b1;
                hw_idx = HWI_W'(j);
            end
        end
    end

    assign mask_take = arb_any && ({1'b0, win_prio} > cur_level);
    assign irq_valid = hw_any || swt_pend || mask_take;
    assign accept    = irq_ack && irq_valid;
    assign acc_hw    = accept && hw_any;
    assign acc_sw    = accept && !hw_any && swt_pend;
    assign acc_mask  = accept && !hw_any && !swt_pend;

    // Form the vector of the presented request by rank.
    always_comb begin
        if (hw_any)        irq_vector = VEC_W'(hw_idx);
        else if (swt_pend) irq_vector = swt_vec;
        else               irq_vector = VEC_W'(N_HWT) + VEC_W'(win_idx);
    end

    // Clear the acknowledged maskable source's request flag.
    always_comb begin
        ack_clr = '0;
        if (acc_mask) ack_clr[win_idx] = 1'b1;
    end

    // Track the current service level through acknowledge and return.
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_level <= '0;
        else if (acc_hw)   cur_level <= LVL_W'(TRAP_LVL);
        else if (acc_mask) cur_level <= {1'b0, win_prio};
        else if (irq_ret && !accept) cur_level <= stk_top;
    end

    // Latch hardware traps until acknowledged; keep sticky trap flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hwt_pend <= '0;
            tflag_q  <= '0;
        end else begin
            hwt_pend <= (hwt_pend & ~(acc_hw ? (N_HWT'(1) << hw_idx) : '0)) | hwt_cond;
            tflag_q  <= (tflag_we ? (tflag_q & tflag_wdata) : tflag_q) | hwt_cond;
        end
    end

    // Latch the software trap and its number until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swt_pend <= 1'b0;
            swt_vec  <= '0;
        end else if (swt_req) begin
            swt_pend <= 1'b1;
            swt_vec  <= swt_num;
        end else if (acc_sw) begin
            swt_pend <= 1'b0;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cur_level == '0 && !irq_valid && tflag_q == '0));
    // R5
    level_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_mask |=> (cur_level > $past(cur_level)));
    // R10
    trap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && hw_any) |=> (cur_level == LVL_W'(TRAP_LVL)));
    // R11
    trap_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hwt_cond) |=> ((tflag_q & $past(hwt_cond)) == $past(hwt_cond)));
endmodule

// File: tb/intc_top_tb_top.sv
module intc_top_tb_top;
    localparam int NS = 8, NH = 4, SD = 8, VW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NS-1:0] src_pulse = '0;
    logic cfg_we = 0, cfg_req = 0, cfg_en = 0;
    logic [2:0] cfg_idx = '0;
    logic [3:0] cfg_prio = '0;
    logic swt_req = 0;
    logic [VW-1:0] swt_num = '0;
    logic [NH-1:0] hwt_cond = '0, tflag_wdata = '0;
    logic tflag_we = 0, irq_ack = 0, irq_ret = 0;
    logic irq_valid;
    logic [VW-1:0] irq_vector;
    logic [4:0] cur_level;
    logic [NH-1:0] tflag_q;

    intc_top #(.N_SRC(NS), .N_HWT(NH), .STACK_DEPTH(SD), .VEC_W(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_req(cfg_req), .cfg_en(cfg_en), .cfg_prio(cfg_prio),
        .swt_req(swt_req), .swt_num(swt_num), .hwt_cond(hwt_cond),
        .tflag_we(tflag_we), .tflag_wdata(tflag_wdata), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .irq_valid(irq_valid), .irq_vector(irq_vector),
        .cur_level(cur_level), .tflag_q(tflag_q)
    );

    always #2.5 clk = ~clk;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;
    string tag = "R1";

    // Reference model state
    bit m_req[NS], m_en[NS];
    int m_prio[NS];
    bit m_hwp[NH], m_tf[NH];
    bit m_swp;
    int m_swn, m_lvl;
    int m_stk[$];

    // kind: 0 none, 1 hw, 2 sw, 3 maskable; returns vector via ref
    function automatic int m_kind(output int vec, output int idx);
        int bp = -1;
        vec = 0; idx = 0;
        for (int j = NH - 1; j >= 0; j--) if (m_hwp[j]) begin vec = j; idx = j; end
        for (int j = 0; j < NH; j++) if (m_hwp[j]) return 1;
        if (m_swp) begin vec = m_swn; return 2; end
        for (int i = 0; i < NS; i++)
            if (m_req[i] && m_en[i] && m_prio[i] > bp) begin bp = m_prio[i]; idx = i; end
        if (bp > m_lvl) begin vec = NH + idx; return 3; end
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_req[i]) begin m_req[i] = 0; m_en[i] = 0; m_prio[i] = 0; end
            foreach (m_hwp[j]) begin m_hwp[j] = 0; m_tf[j] = 0; end
            m_swp = 0; m_swn = 0; m_lvl = 0; m_stk.delete();
        end else begin
            int v, ix, k;
            bit acc;
            k = m_kind(v, ix);
            acc = irq_ack && (k != 0);
            if (acc) begin
                if (m_stk.size() < SD) m_stk.push_back(m_lvl);
                if (k == 1) begin m_lvl = 16; m_hwp[ix] = 0; end
                if (k == 2) m_swp = 0;
                if (k == 3) begin m_lvl = m_prio[ix]; m_req[ix] = 0; end
            end else if (irq_ret) begin
                m_lvl = (m_stk.size() > 0) ? m_stk.pop_back() : 0;
            end
            if (swt_req) begin m_swp = 1; m_swn = swt_num; end
            for (int j = 0; j < NH; j++) begin
                if (tflag_we && !tflag_wdata[j]) m_tf[j] = 0;
                if (hwt_cond[j]) begin m_tf[j] = 1; m_hwp[j] = 1; end
            end
            for (int i = 0; i < NS; i++) begin
                if (cfg_we && cfg_idx == i) begin
                    m_req[i] = cfg_req; m_en[i] = cfg_en; m_prio[i] = cfg_prio;
                end
                if (src_pulse[i]) m_req[i] = 1;
            end
        end
    end

    task automatic chk(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    // Compare every cycle against the model, one edge after stimulus (R12)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int v, ix, k, tf;
            k = m_kind(v, ix);
            tf = 0;
            for (int j = 0; j < NH; j++) tf |= int'(m_tf[j]) << j;
            chk({tag, " valid"}, int'(irq_valid), int'(k != 0));
            if (k != 0) chk({tag, " vector"}, int'(irq_vector), v);
            chk({tag, " level"}, int'(cur_level), m_lvl);
            chk({tag, " tflag"}, int'(tflag_q), tf);
        end
    end

    task automatic step();
        @(negedge clk);
        src_pulse = '0; cfg_we = 0; swt_req = 0; hwt_cond = '0;
        tflag_we = 0; irq_ack = 0; irq_ret = 0;
    endtask

    task automatic cfg(int i, bit r, bit e, int p);
        cfg_we = 1; cfg_idx = 3'(i); cfg_req = r; cfg_en = e; cfg_prio = 4'(p);
        step();
    endtask

    task automatic pulse(int i);
        src_pulse[i] = 1'b1;
        step();
    endtask

    task automatic ack();
        irq_ack = 1; step();
    endtask

    task automatic ret();
        irq_ret = 1; step();
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tag = "R1";
        chk("R1 valid", int'(irq_valid), 0);
        chk("R1 level", int'(cur_level), 0);
        chk("R1 tflag", int'(tflag_q), 0);

        tag = "R8"; cfg(2, 0, 1, 5);
        chk("R8 no request yet", int'(irq_valid), 0);
        tag = "R3"; cfg(3, 0, 0, 9); pulse(3);
        chk("R3 disabled", int'(irq_valid), 0);
        cfg(5, 0, 1, 0); pulse(5);
        chk("R3 prio zero", int'(irq_valid), 0);

        tag = "R2"; pulse(2);
        chk("R12 valid next cycle", int'(irq_valid), 1);
        chk("R2 vector", int'(irq_vector), 6);

        tag = "R4"; cfg(1, 0, 1, 5); pulse(1);
        chk("R4 tie lowest index", int'(irq_vector), 5);
        cfg(6, 0, 1, 7); pulse(6);
        chk("R4 highest prio", int'(irq_vector), 10);

        tag = "R6"; ack();
        chk("R6 level", int'(cur_level), 7);
        tag = "R5";
        chk("R5 lower waits", int'(irq_valid), 0);
        cfg(4, 0, 1, 7); pulse(4);
        chk("R5 equal waits", int'(irq_valid), 0);

        tag = "R6"; cfg(7, 0, 1, 12); pulse(7);
        chk("R6 nested vector", int'(irq_vector), 11);
        ack();
        chk("R6 nested level", int'(cur_level), 12);

        tag = "R9"; swt_req = 1; swt_num = 8'h40; step();
        chk("R9 vector", int'(irq_vector), 64);
        ack();
        chk("R9 level kept", int'(cur_level), 12);

        tag = "R10"; hwt_cond = 4'b0110; step();
        chk("R10 lowest trap", int'(irq_vector), 1);
        chk("R11 flags set", int'(tflag_q), 6);
        ack();
        chk("R10 level", int'(cur_level), 16);
        chk("R10 non-maskable", int'(irq_valid), 1);
        chk("R10 second trap", int'(irq_vector), 2);
        ack();
        chk("R10 drained", int'(irq_valid), 0);
        chk("R11 sticky", int'(tflag_q), 6);

        tag = "R7";
        ret(); chk("R7 pop 1", int'(cur_level), 16);
        ret(); chk("R7 pop 2", int'(cur_level), 12);
        ret(); chk("R7 pop 3", int'(cur_level), 12);
        ret(); chk("R7 pop 4", int'(cur_level), 7);
        ret(); chk("R7 pop 5", int'(cur_level), 0);
        chk("R7 pending resumes", int'(irq_vector), 8);
        ret(); chk("R7 empty pop", int'(cur_level), 0);

        tag = "R8"; cfg(4, 0, 1, 7);
        chk("R8 cleared by write", int'(irq_vector), 5);
        cfg_we = 1; cfg_idx = 3'd0; cfg_req = 0; cfg_en = 1; cfg_prio = 4'd9;
        src_pulse[0] = 1'b1; step();
        chk("R8 pulse beats write", int'(irq_vector), 4);

        tag = "R11"; tflag_we = 1; tflag_wdata = 4'b1011; step();
        chk("R11 write zero clears", int'(tflag_q), 2);
        tflag_we = 1; tflag_wdata = 4'b0000; hwt_cond = 4'b0001; step();
        chk("R11 set wins", int'(tflag_q), 1);
        chk("R10 trap zero", int'(irq_vector), 0);
        ack();
        ret();
        chk("R7 back to zero", int'(cur_level), 0);
        repeat (2) step();
        finish_run();
    end
endmodule